// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a bus-mapped watchdog that counts ticks from one of three tick sources and resets the system if software stops servicing it. Each source arrives as a single-cycle enable that is synchronous to the bus clock. The chosen source passes through a prescaler that divides by a power of four. The prescaled ticks advance a 16-bit counter. When the counter reaches a programmed 16-bit limit, the block raises a reset pulse lasting several cycles and the counter returns to zero.

Software keeps the system alive by writing zero to the counter, known as kicking. It can start the block, stop it and reprogram it through four word-addressed registers. A simple valid/write bus reaches these registers, and read data returns one cycle after the request.

Top module: `tick_watchdog`

## Requirements
- R1: After synchronous reset, all four registers read as zero and `sys_rst_o` is low.
- R2: Register map by word address. 0 is the 16-bit limit. 1 is the run flag in bit 0. 2 is the counter. 3 is the control word: source bits [2:0] (bit 0 = source A, bit 1 = source B, bit 2 = source C) and divider code [5:3]. All other control bits read zero. Read data appears on the cycle after a read request.
- R3: A counter write loads the written value, so writing zero is the kick. It also restarts the prescaler, so the first count after a kick takes a full divided period.
- R4: The counter advances by one per prescaled tick only while the run flag is 1 and at least one source bit is set. With no source bit set, or with the run flag at 0, the counter holds.
- R5: Divider codes 0 to 5 divide the selected source by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 divide by 1024.
- R6: When several source bits are set, the lowest-numbered set bit picks the source, and ticks on the other sources are ignored.
- R7: A control write restarts the prescaler count.
- R8: While running, a counter equal to the limit sets `sys_rst_o` high for exactly 4 cycles starting the next cycle, and the counter returns to zero at that edge.
- R9: The full 16-bit range works: a limit of 0xFFFF is reached and fires.
- R10: The block counts correctly after the following sequence while stopped:
  1. Write a control word with a divider code and no source.
  2. Write the limit.
  3. Clear the counter.
  4. Write the control word again with a source bit.
  5. Set the run flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| src_tick | input | 3 | Per-source single-cycle tick enables |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A wrong prescaler phase or a wrong divider shows as a counter readback that is off by one or more after a known number of ticks. It becomes visible at the first read after the tick burst, which is why kicks and control writes are placed mid-period. A wrong compare or a wrong pulse counter shows on `sys_rst_o`: it rises a cycle early or late, is held for the wrong number of cycles, or the counter reads back nonzero afterwards. The bench samples these on the exact cycles that follow the match edge. A source that counts when it should be ignored shows as a nonzero count after a burst on that source.

// File: rtl/twd_pkg.sv
package twd_pkg;
    parameter int CNT_W        = 16;
    parameter int SRC_N        = 3;
    parameter int PSC_W        = 3;
    parameter int PSC_MAX_CODE = 5;
    parameter int PULSE_LEN    = 4;
    parameter int ADDR_W       = 2;

    localparam int DIV_W   = 2 * PSC_MAX_CODE;
    localparam int PULSE_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [SRC_N-1:0] src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [ADDR_W-1:0] {
        SEL_LIMIT = 2'd0,
        SEL_RUN   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    // terminal prescaler value for a divider code: 4**code - 1, codes above max clamp
    function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
        int c;
        logic [DIV_W-1:0] v;
        c = (int'(code) > PSC_MAX_CODE) ? PSC_MAX_CODE : int'(code);
        v = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < 2 * c) v[i] = 1'b1;
        end
        return v;
    endfunction

    // tick of the lowest-numbered selected source
    function automatic logic pick_tick(input logic [SRC_N-1:0] sel,
                                       input logic [SRC_N-1:0] tick);
        logic hit;
        hit = 1'b0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (sel[i]) hit = tick[i];
        end
        return hit;
    endfunction
endpackage

// File: rtl/twd_regs.sv
module twd_regs
    import twd_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      cnt_val,
    output logic [W-1:0]      limit,
    output logic              run,
    output ctrl_t             ctrl,
    output logic              cnt_we,
    output logic              ctrl_we,
    output logic [W-1:0]      bus_rdata
);
    reg_sel_e sel;
    logic     wr, rd;
    logic [W-1:0] rd_mux;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;
    assign cnt_we  = wr && (sel == SEL_COUNT);
    assign ctrl_we = wr && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
            run   <= 1'b0;
            ctrl  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_LIMIT: limit <= bus_wdata;
                SEL_RUN:   run   <= bus_wdata[0];
                SEL_CTRL:  ctrl  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_LIMIT: rd_mux = limit;
            SEL_RUN:   rd_mux[0] = run;
            SEL_COUNT: rd_mux = cnt_val;
            SEL_CTRL:  rd_mux[CTRL_W-1:0] = ctrl;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    // R2: stored control never holds bits beyond the defined fields after a write
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl == ctrl_t'($past(bus_wdata[CTRL_W-1:0]))));
endmodule

// File: rtl/twd_prescale.sv
module twd_prescale
    import twd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  ctrl_t            ctrl,
    input  logic             restart,
    input  logic [SRC_N-1:0] src_tick,
    output logic             ptick
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] last;
    logic             sel_tick, any_src, step;

    assign last     = div_last(ctrl.psc);
    assign sel_tick = pick_tick(ctrl.src, src_tick);
    assign any_src  = |ctrl.src;
    assign step     = run && any_src && sel_tick;
    assign ptick    = step && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pcnt <= '0;
        end else if (step) begin
            pcnt <= (pcnt == last) ? '0 : pcnt + 1'b1;
        end
    end

    // R5: prescaler phase never exceeds the terminal value of the current code
    pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= last);

    // R6: an output tick needs a tick on some selected source
    ptick_src_chk: assert property (@(posedge clk) disable iff (rst)
        ptick |-> ((ctrl.src & src_tick) != '0));
endmodule

// File: rtl/twd_counter.sv
module twd_counter
    import twd_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    input  logic         ptick,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wval,
    output logic [W-1:0] cnt,
    output logic         sys_rst_o
);
    logic [PULSE_W-1:0] pulse;
    logic               match;

    assign match     = run && (cnt == limit);
    assign sys_rst_o = (pulse != '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (cnt_we) cnt <= cnt_wval;
        else if (match)  cnt <= '0;
        else if (ptick)  cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  pulse <= '0;
        else if (match && !cnt_we) pulse <= PULSE_W'(PULSE_LEN);
        else if (pulse != '0)     pulse <= pulse - 1'b1;
    end

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(cnt));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_we && cnt != limit) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R8
    match_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == limit && !cnt_we) |=> (cnt == '0 && sys_rst_o));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> ($past(sys_rst_o, 1) && $past(sys_rst_o, 2) &&
                              $past(sys_rst_o, 3) && $past(sys_rst_o, 4)));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import twd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [SRC_N-1:0]  src_tick,
    output logic              sys_rst_o
);
    logic [CNT_W-1:0] limit, cnt;
    logic             run, cnt_we, ctrl_we, ptick;
    ctrl_t            ctrl;

    twd_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_val(cnt),
        .limit(limit), .run(run), .ctrl(ctrl),
        .cnt_we(cnt_we), .ctrl_we(ctrl_we), .bus_rdata(bus_rdata)
    );

    twd_prescale u_psc (
        .clk(clk), .rst(rst), .run(run), .ctrl(ctrl),
        .restart(cnt_we || ctrl_we), .src_tick(src_tick), .ptick(ptick)
    );

    twd_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .limit(limit), .ptick(ptick),
        .cnt_we(cnt_we), .cnt_wval(bus_wdata), .cnt(cnt), .sys_rst_o(sys_rst_o)
    );
endmodule

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  src_tick = '0;
    logic        sys_rst_o;

    int checks = 0;
    int fails  = 0;
    logic resp_due = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    tick_watchdog u_tick_watchdog (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .sys_rst_o(sys_rst_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare read responses against the scoreboard queue
    always @(posedge clk) resp_due <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (resp_due && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata, e, t);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic ticks(input logic [2:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = mask;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(16'(sys_rst_o), 16'h0, "R1 sys_rst after reset");
        rd(2'd0, 16'h0000, "R1 limit reset");
        rd(2'd1, 16'h0000, "R1 run reset");
        rd(2'd2, 16'h0000, "R1 count reset");
        rd(2'd3, 16'h0000, "R1 ctrl reset");
        // R2 map and readback
        wr(2'd3, 16'hFFFF); rd(2'd3, 16'h003F, "R2 ctrl unused bits zero");
        wr(2'd0, 16'hA5C3); rd(2'd0, 16'hA5C3, "R2 limit readback");
        wr(2'd1, 16'h0001); rd(2'd1, 16'h0001, "R2 run readback");
        wr(2'd1, 16'h0000); wr(2'd3, 16'h0000);
        // R4 no source selected
        wr(2'd0, 16'd1000); wr(2'd1, 16'h0001);
        ticks(3'b111, 10); rd(2'd2, 16'd0, "R4 no source holds");
        // R4 divide-by-1 counting
        wr(2'd3, 16'h0001); wr(2'd2, 16'h0000);
        ticks(3'b001, 10); rd(2'd2, 16'd10, "R4 count by one");
        wr(2'd1, 16'h0000);
        ticks(3'b001, 10); rd(2'd2, 16'd10, "R4 stopped holds");
        wr(2'd1, 16'h0001);
        // R5 divider codes
        wr(2'd3, 16'h0009); wr(2'd2, 16'h0000);
        ticks(3'b001, 20); rd(2'd2, 16'd5, "R5 divide by 4");
        wr(2'd3, 16'h0011); wr(2'd2, 16'h0000);
        ticks(3'b001, 32); rd(2'd2, 16'd2, "R5 divide by 16");
        wr(2'd3, 16'h0029); wr(2'd2, 16'h0000);
        ticks(3'b001, 1023); rd(2'd2, 16'd0, "R5 divide by 1024 short");
        ticks(3'b001, 1); rd(2'd2, 16'd1, "R5 divide by 1024 full");
        wr(2'd3, 16'h0039); wr(2'd2, 16'h0000);
        ticks(3'b001, 1023); rd(2'd2, 16'd0, "R5 code 7 clamps short");
        ticks(3'b001, 1); rd(2'd2, 16'd1, "R5 code 7 clamps full");
        // R6 source selection and priority
        wr(2'd3, 16'h0002); wr(2'd2, 16'h0000);
        ticks(3'b001, 8); rd(2'd2, 16'd0, "R6 unselected source ignored");
        ticks(3'b010, 8); rd(2'd2, 16'd8, "R6 selected source counts");
        wr(2'd3, 16'h0006); wr(2'd2, 16'h0000);
        ticks(3'b100, 8); rd(2'd2, 16'd0, "R6 higher source loses");
        ticks(3'b010, 8); rd(2'd2, 16'd8, "R6 lowest source wins");
        // R3 kick restarts prescaler
        wr(2'd3, 16'h0009); wr(2'd2, 16'h0000);
        ticks(3'b001, 3); wr(2'd2, 16'h0000);
        ticks(3'b001, 3); rd(2'd2, 16'd0, "R3 kick restarts prescaler");
        ticks(3'b001, 1); rd(2'd2, 16'd1, "R3 full period after kick");
        // R7 control write restarts prescaler
        ticks(3'b001, 3); wr(2'd3, 16'h0009);
        ticks(3'b001, 3); rd(2'd2, 16'd1, "R7 ctrl write restarts prescaler");
        ticks(3'b001, 1); rd(2'd2, 16'd2, "R7 full period after ctrl write");
        // R3 load value
        wr(2'd2, 16'h1234); rd(2'd2, 16'h1234, "R3 counter load");
        // R8 timeout pulse
        wr(2'd0, 16'd3); wr(2'd3, 16'h0001); wr(2'd2, 16'h0000);
        ticks(3'b001, 3);
        check(16'(sys_rst_o), 16'h0, "R8 no pulse before match edge");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(16'(sys_rst_o), 16'h1, "R8 pulse high");
        end
        @(negedge clk);
        check(16'(sys_rst_o), 16'h0, "R8 pulse ends after 4");
        rd(2'd2, 16'd0, "R8 counter back to zero");
        // R9 full range
        wr(2'd0, 16'hFFFF); wr(2'd2, 16'hFFFE);
        ticks(3'b001, 1);
        check(16'(sys_rst_o), 16'h0, "R9 no pulse before match edge");
        @(negedge clk);
        check(16'(sys_rst_o), 16'h1, "R9 limit 0xFFFF fires");
        repeat (5) @(negedge clk);
        rd(2'd2, 16'd0, "R9 counter back to zero");
        // R4 stopped block never fires
        wr(2'd1, 16'h0000); wr(2'd0, 16'd3); wr(2'd2, 16'h0000);
        ticks(3'b001, 5);
        check(16'(sys_rst_o), 16'h0, "R4 stopped no pulse");
        rd(2'd2, 16'd0, "R4 stopped no count");
        // R10 reprogram sequence
        wr(2'd3, 16'h0010); wr(2'd0, 16'h0020); wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0012); wr(2'd1, 16'h0001);
        ticks(3'b010, 32);
        rd(2'd3, 16'h0012, "R10 ctrl after sequence");
        rd(2'd2, 16'd2, "R10 counts after sequence");
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule